// File: doc/BRIEF.md
# Autobaud Serial Receiver with Echo

This block receives asynchronous 8N1 serial characters without being told the line rate in advance. After reset it waits for a calibration character, an uppercase 'U' (0x55). It times how long the start bit of that character stays low, counted in system clock cycles, and keeps that count as the bit period. Because the rate is measured in clock cycles, the block works with any clock frequency for which the count fits. Once locked, it receives characters at the measured rate and hands each one to a downstream parser as a one-cycle valid strobe with its data byte. Every good character, including the calibration 'U', is sent straight back on the transmit line at the same rate.

A measurement that is too short to be a real bit is treated as a glitch and thrown away, and the detector waits for the next falling edge. A character whose stop bit is low raises a framing error pulse and is neither delivered nor echoed. Driving the asynchronous reset low drops the lock, so the next 'U' sets a new rate.

Top module: `abaud_echo_uart`

## Requirements
- R1: While reset is held and directly after it, tx_o is 1, locked_o is 0, bit_period_o is 0, and rx_valid_o and frame_err_o are 0.
- R2: The first falling edge of rx_i after reset starts a measurement. The number of clock cycles that rx_i stays low before it next rises is loaded into bit_period_o, and locked_o goes to 1.
- R3: A low time shorter than MIN_BIT (default 16) cycles is rejected: locked_o stays 0 and the next falling edge starts a new measurement. A low time of exactly MIN_BIT cycles is accepted.
- R4: After the lock, the rest of the calibration character does not appear on rx_valid_o. The calibration character is echoed on tx_o as 0x55.
- R5: Once locked, each character is read with bit 0 first. Every bit is sampled near the middle of its period. The byte is shown on rx_data_o together with a rx_valid_o pulse that lasts exactly one cycle.
- R6: Every character delivered on rx_valid_o is echoed on tx_o at the measured period. The echo frame is a low start bit, the eight data bits with bit 0 first, and a high stop bit. tx_o stays 1 while the block is unlocked.
- R7: A character whose stop bit samples low gives a one-cycle frame_err_o pulse. It gives no rx_valid_o and no echo, and it never coincides with rx_valid_o.
- R8: Taking rst_ni low clears the lock and the measured period. After reset, a new calibration character sets a new rate.
- R9: While locked_o stays 1, bit_period_o does not change, and it is never below MIN_BIT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| tx_o | output | 1 | Serial transmit line carrying the echo, idle high |
| locked_o | output | 1 | High once a bit period has been measured and accepted |
| bit_period_o | output | CNT_W | Measured bit period in clock cycles |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| rx_data_o | output | 8 | Received byte, valid while rx_valid_o is high |
| frame_err_o | output | 1 | One-cycle strobe when a stop bit samples low |

## Verification
The assertions assume that the line holds each bit for a whole number of clock cycles at one fixed rate. They also assume that the calibration character is a real 'U' at a rate no lower than MIN_BIT cycles per bit. Echoes never overlap, because characters are at least one bit time apart, so a new echo never arrives while the transmitter is busy. The stimulus drives rx_i on the falling clock edge with exact bit lengths and leaves two idle bit times after every character. It resets only after the last echo has finished. It uses three rates (40, 24 and the minimum 16 cycles), a rejected 15-cycle glitch, and one character with a low stop bit.

// File: rtl/abaud_pkg.sv
package abaud_pkg;
  localparam logic [7:0] CAL_CHAR = 8'h55;

  typedef enum logic [1:0] {
    M_IDLE,
    M_LOW,
    M_SKIP,
    M_RUN
  } meas_state_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/abaud_meas.sv
module abaud_meas
  import abaud_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MIN_BIT = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic             rx_fall_i,
  output logic             locked_o,
  output logic [CNT_W-1:0] period_o,
  output logic             rx_en_o,
  output logic             cal_echo_o
);
  localparam int SKIP_W = CNT_W + 4;

  meas_state_e        st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [SKIP_W-1:0]  skip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= M_IDLE;
      cnt_q      <= '0;
      skip_q     <= '0;
      locked_o   <= 1'b0;
      period_o   <= '0;
      cal_echo_o <= 1'b0;
    end else begin
      cal_echo_o <= 1'b0;
      case (st_q)
        M_IDLE: if (rx_fall_i) begin
          cnt_q <= CNT_W'(1);
          st_q  <= M_LOW;
        end
        M_LOW: begin
          if (rx_i) begin
            if (cnt_q >= CNT_W'(MIN_BIT)) begin
              period_o <= cnt_q;
              locked_o <= 1'b1;
              // skip the remaining 8 data bits plus half the stop bit
              skip_q   <= ({4'b0, cnt_q} << 3) + ({4'b0, cnt_q} >> 1);
              st_q     <= M_SKIP;
            end else begin
              st_q <= M_IDLE;
            end
          end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        M_SKIP: begin
          if (skip_q <= SKIP_W'(1)) begin
            st_q       <= M_RUN;
            cal_echo_o <= 1'b1;
          end else begin
            skip_q <= skip_q - SKIP_W'(1);
          end
        end
        default: st_q <= M_RUN;
      endcase
    end
  end

  assign rx_en_o = (st_q == M_RUN);
endmodule

// File: rtl/abaud_rx.sv
module abaud_rx
  import abaud_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rx_i,
  input  logic             rx_fall_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             valid_o,
  output logic [7:0]       data_o,
  output logic             ferr_o
);
  rx_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       nbit_q;
  logic [7:0]       shreg_q;
  logic [CNT_W-1:0] half;
  logic             bit_end;

  assign half    = period_i >> 1;
  assign bit_end = (cnt_q == period_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      nbit_q  <= '0;
      shreg_q <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
      ferr_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
      case (st_q)
        RX_IDLE: if (en_i && rx_fall_i) begin
          cnt_q <= '0;
          st_q  <= RX_START;
        end
        RX_START: begin
          if (cnt_q == half - CNT_W'(1)) begin
            cnt_q  <= '0;
            nbit_q <= '0;
            // a start bit gone high at mid-bit is a glitch
            st_q   <= rx_i ? RX_IDLE : RX_DATA;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        RX_DATA: begin
          if (bit_end) begin
            cnt_q   <= '0;
            shreg_q <= {rx_i, shreg_q[7:1]};
            if (nbit_q == 3'd7) st_q <= RX_STOP;
            else nbit_q <= nbit_q + 3'd1;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: begin
          if (bit_end) begin
            cnt_q <= '0;
            st_q  <= RX_IDLE;
            if (rx_i) begin
              valid_o <= 1'b1;
              data_o  <= shreg_q;
            end else begin
              ferr_o <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/abaud_tx.sv
module abaud_tx #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [7:0]       data_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             tx_o
);
  localparam int FRAME_W = 10;

  logic               busy_q;
  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [3:0]         nbit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      shreg_q <= '1;
      cnt_q   <= '0;
      nbit_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        shreg_q <= {1'b1, data_i, 1'b0};
        busy_q  <= 1'b1;
        cnt_q   <= '0;
        nbit_q  <= '0;
      end
    end else if (cnt_q == period_i - CNT_W'(1)) begin
      cnt_q   <= '0;
      shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
      if (nbit_q == 4'(FRAME_W - 1)) busy_q <= 1'b0;
      else nbit_q <= nbit_q + 4'd1;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign tx_o = busy_q ? shreg_q[0] : 1'b1;
endmodule

// File: rtl/abaud_echo_uart.sv
module abaud_echo_uart
  import abaud_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int MIN_BIT     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  output logic             tx_o,
  output logic             locked_o,
  output logic [CNT_W-1:0] bit_period_o,
  output logic             rx_valid_o,
  output logic [7:0]       rx_data_o,
  output logic             frame_err_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_prev_q;
  logic                   rx_s;
  logic                   rx_fall;
  logic                   rx_en;
  logic                   cal_echo;
  logic                   tx_start;
  logic [7:0]             tx_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q    <= '1;
      rx_prev_q <= 1'b1;
    end else begin
      sync_q    <= {sync_q[SYNC_STAGES-2:0], rx_i};
      rx_prev_q <= rx_s;
    end
  end

  assign rx_s    = sync_q[SYNC_STAGES-1];
  assign rx_fall = rx_prev_q & ~rx_s;

  abaud_meas #(.CNT_W(CNT_W), .MIN_BIT(MIN_BIT)) u_meas (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_i       (rx_s),
    .rx_fall_i  (rx_fall),
    .locked_o   (locked_o),
    .period_o   (bit_period_o),
    .rx_en_o    (rx_en),
    .cal_echo_o (cal_echo)
  );

  abaud_rx #(.CNT_W(CNT_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (rx_en),
    .rx_i      (rx_s),
    .rx_fall_i (rx_fall),
    .period_i  (bit_period_o),
    .valid_o   (rx_valid_o),
    .data_o    (rx_data_o),
    .ferr_o    (frame_err_o)
  );

  assign tx_start = cal_echo | rx_valid_o;
  assign tx_data  = cal_echo ? CAL_CHAR : rx_data_o;

  abaud_tx #(.CNT_W(CNT_W)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (tx_start),
    .data_i   (tx_data),
    .period_i (bit_period_o),
    .tx_o     (tx_o)
  );
endmodule

// File: rtl/abaud_chk.sv
module abaud_chk #(
  parameter int CNT_W   = 16,
  parameter int MIN_BIT = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_o,
  input logic             locked_o,
  input logic [CNT_W-1:0] bit_period_o,
  input logic             rx_valid_o,
  input logic             frame_err_o
);
  // R5
  valid_needs_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> locked_o);

  // R5
  valid_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  // R7
  ferr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_valid_o && frame_err_o));

  // R9
  period_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> (locked_o && $stable(bit_period_o)));

  // R3
  period_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> (bit_period_o >= CNT_W'(MIN_BIT)));

  // R6
  tx_idle_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |-> tx_o);
endmodule

bind abaud_echo_uart abaud_chk #(.CNT_W(CNT_W), .MIN_BIT(MIN_BIT)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tx_o         (tx_o),
  .locked_o     (locked_o),
  .bit_period_o (bit_period_o),
  .rx_valid_o   (rx_valid_o),
  .frame_err_o  (frame_err_o)
);

// File: tb/abaud_echo_uart_bench.sv
`timescale 1ns/1ps
module abaud_echo_uart_bench;
  localparam int CNT_W = 16;
  localparam int WD_CYCLES = 150000;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             rx_i = 1'b1;
  logic             tx_o;
  logic             locked_o;
  logic [CNT_W-1:0] bit_period_o;
  logic             rx_valid_o;
  logic [7:0]       rx_data_o;
  logic             frame_err_o;

  int checks = 0;
  int errors = 0;
  int cur_p = 40;
  int ferr_seen = 0;
  logic [7:0] q_rx[$];
  logic [7:0] q_echo[$];

  always #2.5 clk_i = ~clk_i;

  abaud_echo_uart u_abaud_echo_uart (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_i         (rx_i),
    .tx_o         (tx_o),
    .locked_o     (locked_o),
    .bit_period_o (bit_period_o),
    .rx_valid_o   (rx_valid_o),
    .rx_data_o    (rx_data_o),
    .frame_err_o  (frame_err_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
               req, what, act, act, exp, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send_char(input logic [7:0] b, input int p, input bit stop_ok);
    rx_i = 1'b0;
    wait_cyc(p);
    for (int i = 0; i < 8; i++) begin
      rx_i = b[i];
      wait_cyc(p);
    end
    rx_i = stop_ok;
    wait_cyc(p);
    rx_i = 1'b1;
    wait_cyc(2 * p);
  endtask

  task automatic good_char(input logic [7:0] b);
    q_rx.push_back(b);
    q_echo.push_back(b);
    send_char(b, cur_p, 1'b1);
  endtask

  // per-clock model comparison of strobes and idle line
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (rx_valid_o) begin
        if (q_rx.size() == 0) begin
          chk(1'b0, "R4", "unexpected rx_valid byte", int'(rx_data_o), -1);
        end else begin
          logic [7:0] e;
          e = q_rx.pop_front();
          chk(rx_data_o == e, "R5", "received byte", int'(rx_data_o), int'(e));
        end
      end
      if (frame_err_o) ferr_seen++;
      if (!locked_o) chk(tx_o == 1'b1, "R6", "tx idle while unlocked", int'(tx_o), 1);
    end
  end

  // echo decoder
  initial begin
    logic [7:0] b;
    logic [7:0] e;
    forever begin
      @(negedge clk_i);
      if (rst_ni && tx_o == 1'b0) begin
        wait_cyc(cur_p / 2);
        chk(tx_o == 1'b0, "R6", "echo start bit", int'(tx_o), 0);
        for (int i = 0; i < 8; i++) begin
          wait_cyc(cur_p);
          b[i] = tx_o;
        end
        wait_cyc(cur_p);
        chk(tx_o == 1'b1, "R6", "echo stop bit", int'(tx_o), 1);
        if (q_echo.size() == 0) begin
          chk(1'b0, "R6", "unexpected echo", int'(b), -1);
        end else begin
          e = q_echo.pop_front();
          chk(b == e, "R6", "echo byte", int'(b), int'(e));
        end
      end
    end
  end

  initial begin
    wait_cyc(WD_CYCLES);
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(4);
    chk(tx_o == 1'b1, "R1", "tx in reset", int'(tx_o), 1);
    chk(locked_o == 1'b0, "R1", "locked in reset", int'(locked_o), 0);
    chk(bit_period_o == 0, "R1", "period in reset", int'(bit_period_o), 0);
    chk(rx_valid_o == 1'b0 && frame_err_o == 1'b0, "R1", "strobes in reset",
        int'({rx_valid_o, frame_err_o}), 0);
    rst_ni = 1'b1;
    wait_cyc(10);
    chk(locked_o == 1'b0, "R1", "unlocked after reset", int'(locked_o), 0);

    // R2 / R4: calibrate at 40 cycles per bit
    cur_p = 40;
    q_echo.push_back(8'h55);
    send_char(8'h55, cur_p, 1'b1);
    chk(locked_o == 1'b1, "R2", "locked after U", int'(locked_o), 1);
    chk(bit_period_o == 40, "R2", "measured period", int'(bit_period_o), 40);

    good_char(8'hA3);
    good_char(8'h00);
    good_char(8'hFF);
    good_char(8'h5A);
    send_char(8'h3C, cur_p, 1'b0);   // R7 low stop bit
    good_char(8'h81);
    wait_cyc(12 * cur_p);
    chk(ferr_seen == 1, "R7", "frame error pulses", ferr_seen, 1);
    chk(q_rx.size() == 0, "R4", "rx bytes outstanding", q_rx.size(), 0);
    chk(q_echo.size() == 0, "R6", "echoes outstanding", q_echo.size(), 0);
    chk(bit_period_o == 40, "R9", "period held", int'(bit_period_o), 40);

    // R8: reset drops the lock
    rst_ni = 1'b0;
    wait_cyc(3);
    chk(locked_o == 1'b0 && bit_period_o == 0, "R8", "lock cleared",
        int'(bit_period_o), 0);
    rst_ni = 1'b1;
    wait_cyc(10);

    // R3: a 15-cycle glitch is rejected
    rx_i = 1'b0;
    wait_cyc(15);
    rx_i = 1'b1;
    wait_cyc(60);
    chk(locked_o == 1'b0, "R3", "short low rejected", int'(locked_o), 0);

    cur_p = 24;
    q_echo.push_back(8'h55);
    send_char(8'h55, cur_p, 1'b1);
    chk(bit_period_o == 24, "R8", "new rate learned", int'(bit_period_o), 24);
    good_char(8'h7E);
    good_char(8'h01);
    wait_cyc(12 * cur_p);
    chk(q_rx.size() == 0 && q_echo.size() == 0, "R8", "queues drained at 24",
        q_rx.size() + q_echo.size(), 0);

    // R3: exactly MIN_BIT accepted
    rst_ni = 1'b0;
    wait_cyc(3);
    rst_ni = 1'b1;
    wait_cyc(10);
    cur_p = 16;
    q_echo.push_back(8'h55);
    send_char(8'h55, cur_p, 1'b1);
    chk(locked_o == 1'b1 && bit_period_o == 16, "R3", "minimum period accepted",
        int'(bit_period_o), 16);
    good_char(8'hC5);
    wait_cyc(12 * cur_p);
    chk(q_rx.size() == 0 && q_echo.size() == 0, "R5", "queues drained at 16",
        q_rx.size() + q_echo.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule